// File: doc/BRIEF.md
# Speculative Retirement Buffer with Register Rename Table

This block keeps speculatively executed operations in program order until they can retire. It pairs a circular buffer of nine slots with a rename table for the floating-point registers. Each dispatched operation takes the slot at the tail. If it writes a register, that register is renamed to the slot's tag. A result broadcast on the result bus marks the matching slot complete and stores its value. The oldest slot retires once it is complete: a register operation updates the architectural register file, a store is presented with its address and data for memory, and a branch simply leaves.

Two source lookups run each cycle. Each one reports a ready value or the tag of the producer still outstanding. A value that has been broadcast but not yet retired is forwarded from the buffer. When a branch reaches the head marked as mispredicted, it retires and the block discards everything younger: the buffer empties and every rename is dropped. The surrounding issue logic uses the producer tags to wait on the result bus.

Top module: `spec_retire_buf`

## Requirements
- R1: After reset the buffer is empty. `full` and `commitValid` are 0, `dispReady` is 1, `dispTag` is 0, and every register looks up ready with value 0.
- R2: An accepted dispatch takes the tag shown on `dispTag`. Tags advance 0,1,…,DEPTH-1 and then wrap to 0.
- R3: `full` is 1 when all DEPTH slots are occupied. While full, `dispReady` is 0 and a dispatch request is ignored, leaving the tail tag unchanged.
- R4: A dispatch of kind register-op (`dispKind`=0) renames `dispDest` to its tag, so a later lookup returns not-ready with that tag. A newer writer of the same register replaces the older tag.
- R5: A result-bus broadcast (`cdbValid`, `cdbTag`) completes a slot that is waiting. From the next cycle, a lookup of a register renamed to that slot returns ready with the broadcast value, even before retirement.
- R6: Only the head slot retires, and only once complete. At most one slot retires per cycle, strictly in tag order. `commitValid`, `commitTag`, `commitKind`, `commitDest`, `commitAddr` and `commitValue` describe it during that cycle.
- R7: Retiring a register-op writes its value to the architectural file. The register's rename is dropped only if the register still names the retiring tag; otherwise it stays pending on the newer tag.
- R8: A store (`dispKind`=1) renames nothing. It retires with `commitKind`=1 and its dispatch address and broadcast data, and no register changes.
- R9: A branch (`dispKind`=2) whose broadcast carried `cdbMiss`=1 raises `flushOut` when it retires. In that cycle dispatch is refused. From the next cycle the buffer is empty, the tail equals the new head, and all registers look up ready. A branch completed without the flag retires normally.
- R10: A lookup reads the rename state as it stood before a dispatch in the same cycle, so an operation reading its own destination sees the older producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispKind | input | 2 | 0 register-op, 1 store, 2 branch |
| dispDest | input | RW | Destination register (register-op) |
| dispAddr | input | DW | Memory address (store) |
| dispReady | output | 1 | Dispatch will be accepted this cycle |
| dispTag | output | TW | Tag given to the dispatch (tail) |
| full | output | 1 | All slots occupied |
| src1Reg | input | RW | First lookup register |
| src1Ready | output | 1 | First lookup value valid |
| src1Value | output | DW | First lookup value |
| src1Tag | output | TW | First lookup producer tag |
| src2Reg | input | RW | Second lookup register |
| src2Ready | output | 1 | Second lookup value valid |
| src2Value | output | DW | Second lookup value |
| src2Tag | output | TW | Second lookup producer tag |
| cdbValid | input | 1 | Result broadcast valid |
| cdbTag | input | TW | Tag of broadcast result |
| cdbValue | input | DW | Broadcast value |
| cdbMiss | input | 1 | Broadcast branch was mispredicted |
| commitValid | output | 1 | Head slot retires this cycle |
| commitKind | output | 2 | Kind of retiring slot |
| commitDest | output | RW | Destination of retiring register-op |
| commitAddr | output | DW | Address of retiring store |
| commitValue | output | DW | Value or store data |
| commitTag | output | TW | Tag of the head slot |
| flushOut | output | 1 | Mispredicted branch retires, discarding the rest |

## Verification
The bound checker watches the pointer discipline on every cycle. It checks that the tail advances by exactly one with wrap on each accepted dispatch, that it stays still while full, and that retirement walks the tags in order and holds when nothing retires. It also checks that a flush coincides with a branch retiring and leaves the buffer empty. Whether values and renames are right can only be shown by the bench's scenarios and its cycle-by-cycle model. These cover an overwritten rename surviving an older writer's retirement, forwarding of uncommitted results, out-of-order completion behind an incomplete head, stores bypassing the register file, and the rename table clearing after a misprediction.

// File: rtl/srb_pkg.sv
package srb_pkg;

  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    ST_ISSUED  = 2'd0,
    ST_WRITTEN = 2'd2,
    ST_RETIRED = 2'd3
  } slot_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic alloc;
    logic retire;
    logic flush;
  } strobe_t;

endpackage

// File: rtl/srb_ctrl.sv
module srb_ctrl
  import srb_pkg::*;
#(
  parameter int DEPTH = 9,
  localparam int TW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dispValid,
  input  logic          headDone,
  input  logic          headMiss,
  output strobe_t       strobe,
  output logic [TW-1:0] headPtr,
  output logic [TW-1:0] tailPtr,
  output logic          full,
  output logic          dispReady
);

  logic [CW-1:0] count;
  logic          flushNow;

  function automatic logic [TW-1:0] nextPtr(input logic [TW-1:0] p);
    return (p == TW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full          = (count == CW'(DEPTH));
    flushNow      = headDone && headMiss;
    dispReady     = !full && !flushNow;
    strobe.retire = headDone;
    strobe.flush  = flushNow;
    strobe.alloc  = dispValid && dispReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else if (strobe.flush) begin
      headPtr <= nextPtr(headPtr);
      tailPtr <= nextPtr(headPtr);
      count   <= '0;
    end else begin
      if (strobe.retire) headPtr <= nextPtr(headPtr);
      if (strobe.alloc)  tailPtr <= nextPtr(tailPtr);
      case ({strobe.alloc, strobe.retire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/srb_data.sv
module srb_data
  import srb_pkg::*;
#(
  parameter int DEPTH = 9,
  parameter int NREG  = 8,
  parameter int DW    = 32,
  parameter int NSRC  = 2,
  localparam int TW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strobe,
  input  logic [TW-1:0]             headPtr,
  input  logic [TW-1:0]             tailPtr,
  input  logic [1:0]                dispKind,
  input  logic [RW-1:0]             dispDest,
  input  logic [DW-1:0]             dispAddr,
  input  logic [NSRC-1:0][RW-1:0]   srcReg,
  output logic [NSRC-1:0]           srcReady,
  output logic [NSRC-1:0][DW-1:0]   srcValue,
  output logic [NSRC-1:0][TW-1:0]   srcTag,
  input  logic                      cdbValid,
  input  logic [TW-1:0]             cdbTag,
  input  logic [DW-1:0]             cdbValue,
  input  logic                      cdbMiss,
  output logic                      headDone,
  output logic                      headMiss,
  output logic [1:0]                commitKind,
  output logic [RW-1:0]             commitDest,
  output logic [DW-1:0]             commitAddr,
  output logic [DW-1:0]             commitValue
);

  typedef struct packed {
    logic          busy;
    slot_state_e   st;
    logic [1:0]    kind;
    logic [RW-1:0] dest;
    logic [DW-1:0] addr;
    logic [DW-1:0] val;
    logic          miss;
  } slot_t;

  slot_t         slots  [DEPTH];
  logic          regBusy[NREG];
  logic [TW-1:0] regTag [NREG];
  logic [DW-1:0] archReg[NREG];

  slot_t headSlot;

  always_comb begin
    headSlot    = slots[headPtr];
    headDone    = headSlot.busy && (headSlot.st == ST_WRITTEN);
    headMiss    = (headSlot.kind == KIND_BRANCH) && headSlot.miss;
    commitKind  = headSlot.kind;
    commitDest  = headSlot.dest;
    commitAddr  = headSlot.addr;
    commitValue = headSlot.val;
  end

  // source lookups: architectural value, buffered value, or producer tag
  for (genvar g = 0; g < NSRC; g++) begin : g_lookup
    always_comb begin
      srcTag[g] = regTag[srcReg[g]];
      if (!regBusy[srcReg[g]]) begin
        srcReady[g] = 1'b1;
        srcValue[g] = archReg[srcReg[g]];
      end else if (slots[regTag[srcReg[g]]].st == ST_WRITTEN) begin
        srcReady[g] = 1'b1;
        srcValue[g] = slots[regTag[srcReg[g]]].val;
      end else begin
        srcReady[g] = 1'b0;
        srcValue[g] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        slots[i] <= '{busy: 1'b0, st: ST_RETIRED, kind: 2'd0, dest: '0,
                      addr: '0, val: '0, miss: 1'b0};
      end
      for (int r = 0; r < NREG; r++) begin
        regBusy[r] <= 1'b0;
        regTag[r]  <= '0;
        archReg[r] <= '0;
      end
    end else if (strobe.flush) begin
      for (int i = 0; i < DEPTH; i++) begin
        slots[i].busy <= 1'b0;
        slots[i].st   <= ST_RETIRED;
      end
      for (int r = 0; r < NREG; r++) regBusy[r] <= 1'b0;
    end else begin
      // result bus snoop
      for (int i = 0; i < DEPTH; i++) begin
        if (cdbValid && cdbTag == TW'(i) && slots[i].busy && slots[i].st == ST_ISSUED) begin
          slots[i].st   <= ST_WRITTEN;
          slots[i].val  <= cdbValue;
          slots[i].miss <= cdbMiss;
        end
      end
      // retirement of the head
      if (strobe.retire) begin
        slots[headPtr].busy <= 1'b0;
        slots[headPtr].st   <= ST_RETIRED;
        if (headSlot.kind == KIND_REG) begin
          archReg[headSlot.dest] <= headSlot.val;
          if (regBusy[headSlot.dest] && regTag[headSlot.dest] == headPtr)
            regBusy[headSlot.dest] <= 1'b0;
        end
      end
      // allocation at the tail; a new rename wins over a clear
      if (strobe.alloc) begin
        slots[tailPtr] <= '{busy: 1'b1, st: ST_ISSUED, kind: dispKind, dest: dispDest,
                            addr: dispAddr, val: '0, miss: 1'b0};
        if (dispKind == KIND_REG) begin
          regBusy[dispDest] <= 1'b1;
          regTag[dispDest]  <= tailPtr;
        end
      end
    end
  end

endmodule

// File: rtl/spec_retire_buf.sv
module spec_retire_buf
  import srb_pkg::*;
#(
  parameter int DEPTH = 9,
  parameter int NREG  = 8,
  parameter int DW    = 32,
  localparam int TW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dispValid,
  input  logic [1:0]    dispKind,
  input  logic [RW-1:0] dispDest,
  input  logic [DW-1:0] dispAddr,
  output logic          dispReady,
  output logic [TW-1:0] dispTag,
  output logic          full,
  input  logic [RW-1:0] src1Reg,
  output logic          src1Ready,
  output logic [DW-1:0] src1Value,
  output logic [TW-1:0] src1Tag,
  input  logic [RW-1:0] src2Reg,
  output logic          src2Ready,
  output logic [DW-1:0] src2Value,
  output logic [TW-1:0] src2Tag,
  input  logic          cdbValid,
  input  logic [TW-1:0] cdbTag,
  input  logic [DW-1:0] cdbValue,
  input  logic          cdbMiss,
  output logic          commitValid,
  output logic [1:0]    commitKind,
  output logic [RW-1:0] commitDest,
  output logic [DW-1:0] commitAddr,
  output logic [DW-1:0] commitValue,
  output logic [TW-1:0] commitTag,
  output logic          flushOut
);

  strobe_t          strobe;
  logic [TW-1:0]    headPtr;
  logic [TW-1:0]    tailPtr;
  logic             headDone;
  logic             headMiss;
  logic [1:0][RW-1:0] srcRegs;
  logic [1:0]         srcRdy;
  logic [1:0][DW-1:0] srcVal;
  logic [1:0][TW-1:0] srcTg;

  assign srcRegs = {src2Reg, src1Reg};
  assign {src2Ready, src1Ready} = srcRdy;
  assign src1Value = srcVal[0];
  assign src2Value = srcVal[1];
  assign src1Tag   = srcTg[0];
  assign src2Tag   = srcTg[1];

  srb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid),
    .headDone(headDone), .headMiss(headMiss), .strobe(strobe),
    .headPtr(headPtr), .tailPtr(tailPtr), .full(full), .dispReady(dispReady)
  );

  srb_data #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW), .NSRC(2)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headPtr(headPtr), .tailPtr(tailPtr),
    .dispKind(dispKind), .dispDest(dispDest), .dispAddr(dispAddr),
    .srcReg(srcRegs), .srcReady(srcRdy), .srcValue(srcVal), .srcTag(srcTg),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbValue(cdbValue), .cdbMiss(cdbMiss),
    .headDone(headDone), .headMiss(headMiss), .commitKind(commitKind),
    .commitDest(commitDest), .commitAddr(commitAddr), .commitValue(commitValue)
  );

  assign dispTag     = tailPtr;
  assign commitTag   = headPtr;
  assign commitValid = strobe.retire;
  assign flushOut    = strobe.flush;

endmodule

// File: rtl/srb_check.sv
module srb_check #(
  parameter int DEPTH = 9,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          dispValid,
  input logic          dispReady,
  input logic [TW-1:0] dispTag,
  input logic          full,
  input logic          commitValid,
  input logic [1:0]    commitKind,
  input logic [TW-1:0] commitTag,
  input logic          flushOut
);

  function automatic logic [TW-1:0] stepTag(input logic [TW-1:0] p);
    return (p == TW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  p_tag_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && dispReady |=> dispTag == stepTag($past(dispTag)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    full && !flushOut |=> $stable(dispTag));

  p_commit_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    commitValid && !flushOut |=> commitTag == stepTag($past(commitTag)));

  p_head_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !commitValid |=> $stable(commitTag));

  p_flush_branch_r9: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> commitValid && commitKind == 2'd2);

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> dispTag == commitTag && !full && !commitValid);

endmodule

bind spec_retire_buf srb_check #(.DEPTH(DEPTH), .TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady),
  .dispTag(dispTag), .full(full), .commitValid(commitValid),
  .commitKind(commitKind), .commitTag(commitTag), .flushOut(flushOut)
);

// File: tb/spec_retire_buf_tb.sv
`timescale 1ns/1ps
module spec_retire_buf_tb;

  localparam int DEPTH = 9;

  logic        clk = 1'b0;
  logic        rstN;
  logic        dispValid;
  logic [1:0]  dispKind;
  logic [2:0]  dispDest;
  logic [31:0] dispAddr;
  logic        dispReady;
  logic [3:0]  dispTag;
  logic        full;
  logic [2:0]  src1Reg, src2Reg;
  logic        src1Ready, src2Ready;
  logic [31:0] src1Value, src2Value;
  logic [3:0]  src1Tag, src2Tag;
  logic        cdbValid;
  logic [3:0]  cdbTag;
  logic [31:0] cdbValue;
  logic        cdbMiss;
  logic        commitValid;
  logic [1:0]  commitKind;
  logic [2:0]  commitDest;
  logic [31:0] commitAddr, commitValue;
  logic [3:0]  commitTag;
  logic        flushOut;

  spec_retire_buf u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // behavioural reference model
  typedef struct {
    int     tag;
    int     kind;
    int     dest;
    longint addr;
    bit     done;
    longint value;
    bit     miss;
  } mslot_t;

  mslot_t q[$];
  bit     mBusy[8];
  int     mTag[8];
  longint mArf[8];
  int     mTail;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic look(input int r, output bit rdy, output longint val, output int tag);
    rdy = 1'b0; val = 0; tag = -1;
    if (!mBusy[r]) begin
      rdy = 1'b1; val = mArf[r];
    end else begin
      tag = mTag[r];
      foreach (q[i]) if (q[i].tag == tag && q[i].done) begin
        rdy = 1'b1; val = q[i].value;
      end
    end
  endtask

  task automatic cmpSrc(input int r, input logic rdy, input logic [31:0] val,
                        input logic [3:0] tg);
    bit eRdy; longint eVal; int eTag;
    look(r, eRdy, eVal, eTag);
    chk("R5 lookup ready", rdy, eRdy);
    if (eRdy) chk("R5 lookup value", val, eVal);
    else      chk("R4 lookup tag", tg, eTag);
  endtask

  task automatic step(input bit dv, input int kind, input int dest, input longint addr,
                      input int s1, input int s2, input bit cv, input int ctag,
                      input longint cval, input bit cmiss);
    bit commitE, flushE, acceptE;
    mslot_t h;
    @(negedge clk);
    dispValid = dv; dispKind = 2'(kind); dispDest = 3'(dest); dispAddr = 32'(addr);
    src1Reg = 3'(s1); src2Reg = 3'(s2);
    cdbValid = cv; cdbTag = 4'(ctag); cdbValue = 32'(cval); cdbMiss = cmiss;
    #2;
    commitE = q.size() > 0 && q[0].done;
    flushE  = commitE && q[0].kind == 2 && q[0].miss;
    acceptE = dv && q.size() < DEPTH && !flushE;
    chk("R3 full", full, q.size() == DEPTH);
    chk("R3 dispReady", dispReady, q.size() < DEPTH && !flushE);
    chk("R2 dispTag", dispTag, mTail);
    chk("R6 commitValid", commitValid, commitE);
    chk("R9 flushOut", flushOut, flushE);
    if (commitE) begin
      chk("R6 commitTag", commitTag, q[0].tag);
      chk("R6 commitKind", commitKind, q[0].kind);
      if (q[0].kind == 0) begin
        chk("R7 commitDest", commitDest, q[0].dest);
        chk("R7 commitValue", commitValue, q[0].value);
      end else if (q[0].kind == 1) begin
        chk("R8 commitAddr", commitAddr, q[0].addr);
        chk("R8 commitValue", commitValue, q[0].value);
      end
    end
    cmpSrc(s1, src1Ready, src1Value, src1Tag);
    cmpSrc(s2, src2Ready, src2Value, src2Tag);
    // model update for the coming edge
    if (commitE) begin
      h = q.pop_front();
      if (h.kind == 0) begin
        mArf[h.dest] = h.value;
        if (mBusy[h.dest] && mTag[h.dest] == h.tag) mBusy[h.dest] = 1'b0;
      end
      if (flushE) begin
        q.delete();
        foreach (mBusy[r]) mBusy[r] = 1'b0;
        mTail = (h.tag + 1) % DEPTH;
      end
    end
    if (cv && !flushE) begin
      foreach (q[i]) if (q[i].tag == ctag && !q[i].done) begin
        q[i].done = 1'b1; q[i].value = cval; q[i].miss = cmiss;
      end
    end
    if (acceptE) begin
      q.push_back('{tag: mTail, kind: kind, dest: dest, addr: addr,
                    done: 1'b0, value: 0, miss: 1'b0});
      if (kind == 0) begin
        mBusy[dest] = 1'b1; mTag[dest] = mTail;
      end
      mTail = (mTail + 1) % DEPTH;
    end
  endtask

  task automatic idle(input int s1, input int s2);
    step(0, 0, 0, 0, s1, s2, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    finishRun();
  end

  initial begin
    foreach (mBusy[r]) begin mBusy[r] = 0; mTag[r] = 0; mArf[r] = 0; end
    mTail = 0;
    rstN = 0; dispValid = 0; dispKind = 0; dispDest = 0; dispAddr = 0;
    src1Reg = 0; src2Reg = 0; cdbValid = 0; cdbTag = 0; cdbValue = 0; cdbMiss = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // reset state
    idle(3, 6);
    chk("R1 full", full, 0);
    chk("R1 dispReady", dispReady, 1);
    chk("R1 commitValid", commitValid, 0);
    chk("R1 dispTag", dispTag, 0);
    chk("R1 src1Ready", src1Ready, 1);
    chk("R1 src1Value", src1Value, 0);

    // rename, overwrite, completion and retirement
    step(1, 0, 0, 0, 0, 2, 0, 0, 0, 0);
    chk("R10 own dest seen ready", src1Ready, 1);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 renamed not ready", src1Ready, 0);
    chk("R4 renamed tag", src1Tag, 0);
    chk("R10 old producer", src1Tag, 0);
    idle(0, 1);
    chk("R4 newer writer tag", src1Tag, 1);
    step(0, 0, 0, 0, 0, 1, 1, 0, 100, 0);
    idle(0, 1);
    chk("R6 head retires", commitValid, 1);
    chk("R6 retire tag", commitTag, 0);
    chk("R7 retire value", commitValue, 100);
    idle(0, 1);
    chk("R7 rename kept by newer", src1Ready, 0);
    chk("R7 rename kept tag", src1Tag, 1);
    step(0, 0, 0, 0, 0, 1, 1, 1, 200, 0);
    idle(0, 1);
    chk("R5 forwarded ready", src1Ready, 1);
    chk("R5 forwarded value", src1Value, 200);
    idle(0, 1);
    chk("R7 arch value", src1Value, 200);
    chk("R7 rename cleared", src1Ready, 1);

    // store
    step(1, 1, 5, 'h40, 5, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 5, 0, 1, 2, 55, 0);
    idle(5, 0);
    chk("R8 store kind", commitKind, 1);
    chk("R8 store addr", commitAddr, 'h40);
    chk("R8 store data", commitValue, 55);
    idle(5, 0);
    chk("R8 no register change", src1Ready, 1);
    chk("R8 no register value", src1Value, 0);

    // fill to capacity with wrap
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 0, i % 8, 0, i % 8, 0, 0, 0, 0, 0);
      chk("R2 wrap tag", dispTag, (3 + i) % DEPTH);
    end
    idle(0, 1);
    chk("R3 full set", full, 1);
    chk("R3 refuse", dispReady, 0);
    step(1, 0, 7, 0, 7, 0, 0, 0, 0, 0);
    idle(7, 0);
    chk("R3 ignored dispatch tag", dispTag, 3);
    chk("R3 still full", full, 1);
    step(0, 0, 0, 0, 0, 1, 1, 5, 7, 0);
    idle(0, 2);
    chk("R6 no retire behind head", commitValid, 0);
    foreach (q[i]) ;
    begin
      int order[8] = '{3, 4, 6, 7, 8, 0, 1, 2};
      foreach (order[k]) step(0, 0, 0, 0, k % 8, 0, 1, order[k], 1000 + k, 0);
    end
    repeat (12) idle(0, 1);
    chk("R6 drained", full, 0);

    // mispredicted branch
    step(1, 2, 0, 0, 1, 2, 0, 0, 0, 0);
    step(1, 0, 1, 0, 1, 2, 0, 0, 0, 0);
    step(1, 1, 0, 'h80, 1, 2, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 2, 1, 4, 9, 0);
    step(0, 0, 0, 0, 1, 2, 1, 3, 0, 1);
    step(1, 0, 2, 0, 1, 2, 0, 0, 0, 0);
    chk("R9 flush", flushOut, 1);
    chk("R9 branch kind", commitKind, 2);
    chk("R9 dispatch refused", dispReady, 0);
    idle(1, 2);
    chk("R9 empty", commitValid, 0);
    chk("R9 tail at head", dispTag, 4);
    chk("R9 reg cleared", src1Ready, 1);
    chk("R9 refused dispatch no rename", src2Ready, 1);

    // correctly predicted branch
    step(1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 4, 0, 0);
    idle(0, 0);
    chk("R9 normal branch retires", commitValid, 1);
    chk("R9 no flush", flushOut, 0);
    repeat (3) idle(0, 0);

    finishRun();
  end

endmodule